// File: doc/BRIEF.md
# Interruptible Sequential Memory Fill Engine

This block fills a run of memory words with an ascending sequence. A one-cycle start pulse supplies a first value, a first address and a word count. From the next cycle the engine issues one write per clock on a simple synchronous single-port write interface. After each write both the value and the address step up by one. The count steps down until the run is used up.

The run can be interrupted. The engine samples an interrupt request at the end of every write. If words are still left at that point, it drops the operation. It then returns its visible value and address registers to what they held at the start and flags that the whole operation has to be reissued. A normal finish leaves the value register at zero and the address register one past the last word written. The host can then carry on from there.

Top module: `fill_engine`

## Requirements
- R1: A start pulse while idle loads the operation. The first write happens in the cycle after the pulse, at the start address with its top bit (bit 15) cleared, and carries the start value.
- R2: While busy the engine writes exactly one word per cycle. Each write's value is the previous value plus one modulo 2^16. Each write's address is the previous address plus one modulo 2^15.
- R3: A count of N (1 to 65535) writes exactly N words. A count of 0 writes 65536 words.
- R4: On normal completion `done` is high for exactly one cycle with `restart` low. At that point `value_out` is 0 and `addr_out` is one past the last address written, wrapped to 15 bits with bit 15 zero.
- R5: If `irq` is high at the end of a write and words remain, the engine aborts. `done` and `restart` are both high for one cycle. `value_out` returns to the start value and `addr_out` returns to the original start address, including its bit 15. No further write is issued.
- R6: `irq` during the last word, or held high from the start, still lets at least one word be written. It has no effect on a run whose final write is in progress, and that run completes normally.
- R7: `mem_we` is high only in cycles that carry a real write. It is low while idle and in the `done` cycle.
- R8: A start pulse while busy is ignored. The running sequence continues unchanged.
- R9: After reset `busy`, `mem_we`, `done` and `restart` are low, and `value_out` and `addr_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only while idle |
| start_value | input | 16 | First value written |
| start_addr | input | 16 | First address; bit 15 is dropped for writing but kept for restore |
| word_count | input | 16 | Number of words, 0 meaning 65536 |
| irq | input | 1 | Interrupt request, sampled at the end of each write |
| mem_addr | output | 15 | Write address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at completion or abort |
| restart | output | 1 | High with `done` when the run was aborted |
| value_out | output | 16 | Value register as seen by the host |
| addr_out | output | 16 | Address register as seen by the host |

## Verification
The first write is due one cycle after the start pulse. Every later write is due exactly one cycle after the one before it. `done`, `restart` and the result registers are due one cycle after the final or aborting write. The bench drives inputs and samples outputs on the falling edge. It steps through a run one cycle at a time and compares each write with the expected value and address in that same cycle. It reads the result in the cycle right after the expected last write, then confirms that `done` has dropped one cycle later. The interrupt is raised from a chosen write index. The expected number of writes and the expected outcome follow directly from that index and the count.

// File: rtl/fill_pkg.sv
package fill_pkg;

    parameter int DEF_DATA_W = 16;
    parameter int DEF_ADDR_W = 15;
    parameter int DEF_CNT_W  = 16;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // outcome of the write issued in the current cycle
    typedef enum logic [1:0] {
        STEP_NONE   = 2'd0,
        STEP_MORE   = 2'd1,
        STEP_FINISH = 2'd2,
        STEP_ABORT  = 2'd3
    } step_kind_e;

    function automatic step_kind_e classify_step(input logic running,
                                                 input logic last_word,
                                                 input logic irq_seen);
        if (!running)       return STEP_NONE;
        else if (last_word) return STEP_FINISH;
        else if (irq_seen)  return STEP_ABORT;
        else                return STEP_MORE;
    endfunction

endpackage

// File: rtl/fill_seq.sv
module fill_seq
    import fill_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       irq,
    input  logic       last_word,
    output logic       busy,
    output logic       load,
    output step_kind_e step,
    output logic       done,
    output logic       restart
);
    seq_state_e state_q;
    logic       done_q;
    logic       restart_q;

    assign busy = (state_q == SEQ_RUN);
    assign load = start && (state_q == SEQ_IDLE);
    assign step = classify_step(busy, last_word, irq);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            done_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            restart_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: if (start) state_q <= SEQ_RUN;
                default: begin
                    if (step == STEP_FINISH || step == STEP_ABORT) begin
                        state_q   <= SEQ_IDLE;
                        done_q    <= 1'b1;
                        restart_q <= (step == STEP_ABORT);
                    end
                end
            endcase
        end
    end

    assign done    = done_q;
    assign restart = restart_q;
endmodule

// File: rtl/fill_walker.sv
module fill_walker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-1:0] init_value,
    input  logic [ADDR_W:0]   init_addr,
    input  logic [CNT_W-1:0]  init_count,
    output logic [DATA_W-1:0] cur_value,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              last_word
);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

    logic [DATA_W-1:0] val_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    assign next_addr = addr_q + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q  <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            val_q  <= init_value;
            addr_q <= init_addr[ADDR_W-1:0];   // direct address only
            cnt_q  <= init_count;
        end else if (advance) begin
            val_q  <= val_q + DATA_W'(1);
            addr_q <= next_addr;
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    assign cur_value = val_q;
    assign cur_addr  = addr_q;
    assign last_word = (cnt_q == ONE_LEFT);
endmodule

// File: rtl/fill_snapshot.sv
module fill_snapshot
    import fill_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  step_kind_e        step,
    input  logic [DATA_W-1:0] init_value,
    input  logic [ADDR_W:0]   init_addr,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [DATA_W-1:0] value_reg,
    output logic [ADDR_W:0]   addr_reg
);
    logic [DATA_W-1:0] saved_val_q;
    logic [ADDR_W:0]   saved_addr_q;
    logic [DATA_W-1:0] vis_val_q;
    logic [ADDR_W:0]   vis_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_val_q  <= '0;
            saved_addr_q <= '0;
        end else if (load) begin
            saved_val_q  <= init_value;
            saved_addr_q <= init_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_val_q  <= '0;
            vis_addr_q <= '0;
        end else if (load) begin
            vis_val_q  <= '0;
            vis_addr_q <= {1'b0, init_addr[ADDR_W-1:0]};
        end else begin
            case (step)
                STEP_MORE, STEP_FINISH: vis_addr_q <= {1'b0, next_addr};
                STEP_ABORT: begin
                    vis_val_q  <= saved_val_q;
                    vis_addr_q <= saved_addr_q;
                end
                default: ;
            endcase
        end
    end

    assign value_reg = vis_val_q;
    assign addr_reg  = vis_addr_q;
endmodule

// File: rtl/fill_engine.sv
module fill_engine
    import fill_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] start_value,
    input  logic [ADDR_W:0]   start_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              irq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic              restart,
    output logic [DATA_W-1:0] value_out,
    output logic [ADDR_W:0]   addr_out
);
    logic              load;
    logic              last_word;
    step_kind_e        step;
    logic [DATA_W-1:0] cur_value;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] next_addr;

    fill_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .irq       (irq),
        .last_word (last_word),
        .busy      (busy),
        .load      (load),
        .step      (step),
        .done      (done),
        .restart   (restart)
    );

    fill_walker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .advance    (step == STEP_MORE),
        .init_value (start_value),
        .init_addr  (start_addr),
        .init_count (word_count),
        .cur_value  (cur_value),
        .cur_addr   (cur_addr),
        .next_addr  (next_addr),
        .last_word  (last_word)
    );

    fill_snapshot #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_snap (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .init_value (start_value),
        .init_addr  (start_addr),
        .next_addr  (next_addr),
        .value_reg  (value_out),
        .addr_reg   (addr_out)
    );

    assign mem_we    = busy;
    assign mem_addr  = cur_addr;
    assign mem_wdata = cur_value;
endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              done,
    input logic              restart,
    input logic [DATA_W-1:0] value_out
);
    assert_first_write_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(start));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    assert_data_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> mem_wdata == DATA_W'($past(mem_wdata) + 1'b1));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_clear_value_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !restart) |-> value_out == '0);

    assert_restart_qual_R5: assert property (@(posedge clk) disable iff (rst)
        restart |-> done);

    assert_quiet_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);
endmodule

bind fill_engine fill_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .done      (done),
    .restart   (restart),
    .value_out (value_out)
);

// File: tb/sim_fill_engine.sv
module sim_fill_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] start_value = '0;
    logic [15:0] start_addr = '0;
    logic [15:0] word_count = '0;
    logic        irq = 1'b0;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic        busy, done, restart;
    logic [15:0] value_out;
    logic [15:0] addr_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles++;

    fill_engine u0 (
        .clk(clk), .rst(rst), .start(start), .start_value(start_value),
        .start_addr(start_addr), .word_count(word_count), .irq(irq),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .busy(busy), .done(done), .restart(restart),
        .value_out(value_out), .addr_out(addr_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int run_length(input logic [15:0] cnt);
        return (cnt == 16'd0) ? 65536 : int'(cnt);
    endfunction

    function automatic int writes_due(input int n, input int irq_at);
        return (irq_at != 0 && irq_at < n) ? irq_at : n;
    endfunction

    function automatic logic [14:0] addr_at(input logic [15:0] sa, input int k);
        return 15'(int'(sa[14:0]) + k);
    endfunction

    // irq_at: write index from which irq is held high (0 = never)
    task automatic run(input logic [15:0] sv, input logic [15:0] sa,
                       input logic [15:0] cnt, input int irq_at, input bit glitch);
        int n = run_length(cnt);
        int due = writes_due(n, irq_at);
        bit aborted = (due < n);
        int stream_bad = 0;
        int w;
        @(negedge clk);
        start = 1'b1; start_value = sv; start_addr = sa; word_count = cnt;
        @(negedge clk);
        start = 1'b0;
        // R1: first write one cycle after the start pulse
        check(mem_we && mem_addr == sa[14:0] && mem_wdata == sv, "R1", "first write",
              int'(mem_addr), int'(sa[14:0]));
        for (w = 1; w <= due; w++) begin
            irq = (irq_at != 0 && w >= irq_at);
            // R8: a pulse with other arguments during the run
            if (glitch && w == 2 && due >= 3) begin
                start = 1'b1; start_value = ~sv; start_addr = sa ^ 16'h1234; word_count = 16'd2;
            end else start = 1'b0;
            if (!mem_we || done || mem_addr != addr_at(sa, w-1) ||
                mem_wdata != 16'(int'(sv) + w - 1)) stream_bad++;
            @(negedge clk);
        end
        irq = 1'b0;
        start = 1'b0;
        check(stream_bad == 0, glitch ? "R8" : "R2", "write stream mismatches", stream_bad, 0);
        // R3/R7: writes stop exactly after the due count
        check(!mem_we && done, "R3", "stop after due writes", {mem_we, done}, 1);
        if (aborted) begin
            check(restart && value_out == sv && addr_out == sa, "R5", "abort restore",
                  int'(addr_out), int'(sa));
        end else begin
            check(!restart && value_out == 16'd0 && addr_out == {1'b0, addr_at(sa, n)},
                  irq_at != 0 ? "R6" : "R4", "completion registers",
                  int'(addr_out), int'({1'b0, addr_at(sa, n)}));
        end
        @(negedge clk);
        check(!done && !restart && !mem_we && !busy, "R4", "done one cycle",
              {done, restart, mem_we, busy}, 0);
    endtask

    initial begin : watchdog
        wait (cycles > WATCHDOG);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy && !mem_we && !done && !restart && value_out == 0 && addr_out == 0,
              "R9", "reset state", {busy, mem_we, done, restart}, 0);
        rst = 1'b0;
        @(negedge clk);
        // R7 idle: no write
        check(!mem_we, "R7", "idle no write", int'(mem_we), 0);

        run(16'h0100, 16'h0040, 16'd5, 0, 0);        // R4 plain run
        run(16'hFFFE, 16'h7FFE, 16'd4, 0, 0);        // R2 wrap of value and address
        run(16'h1111, 16'hC123, 16'd3, 0, 0);        // R1 bit 15 dropped
        run(16'h2222, 16'h8200, 16'd6, 3, 0);        // R5 abort keeps bit 15
        run(16'h3333, 16'h0010, 16'd1, 1, 0);        // R6 irq held from start, one word
        run(16'h4444, 16'h0020, 16'd4, 4, 0);        // R6 irq only on last word
        run(16'h5555, 16'h0030, 16'd8, 0, 1);        // R8 start while busy
        run(16'h6666, 16'h0050, 16'd5, 1, 0);        // R5 abort after first word
        for (int i = 0; i < 24; i++) begin
            run(16'($urandom), 16'($urandom), 16'($urandom_range(1, 20)),
                int'($urandom_range(0, 24)), 1'($urandom_range(0, 1)));
        end
        run(16'h0007, 16'h7000, 16'd0, 0, 0);        // R3 count zero: 65536 words
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule